// File: doc/BRIEF.md
# ADC Frame Reader

This block is a serial-bus master that fetches one 14-bit conversion result from a serial-output analog-to-digital converter. It uses SPI mode 0: the serial clock idles low, and data is sampled on the rising edge. When the block sees a one-cycle `start` request, it lowers the active-low select. It then produces 24 serial clock pulses, made by dividing the system clock. On each rising edge it shifts in one bit from the data line.

The 24-bit frame has three parts: a leading byte that should be all zeros, the 14 result bits MSB first, and two status bits. The result spans a byte boundary, and the block separates the bits into distinct result and status outputs. When the frame ends, the block releases the select and pulses `done` for one system clock. It raises `frame_error` in the same cycle if any leading bit was a one.

The controller has five states:
- `ST_IDLE`: select high, clock low.
- `ST_SETUP`: select low, clock held low for a half period.
- `ST_HIGH`: clock high.
- `ST_LOW`: clock low.
- `ST_DONE`: select released, done pulse.

The transitions are:
- IDLE→SETUP on `start`.
- SETUP→HIGH when a half period ends; this transition samples the data line.
- HIGH→LOW when a half period ends and bits remain.
- LOW→HIGH when a half period ends; this transition samples the data line.
- HIGH→DONE when the half period after the 24th sample ends.
- DONE→IDLE unconditionally.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `cs_n` is 1, and `sclk`, `busy`, `done` and `frame_error` are 0.
- R2: A `start` accepted in idle drives `cs_n` low on the next cycle. The first rising edge of `sclk` follows exactly HALF_DIV system cycles after `cs_n` falls.
- R3: Within a frame, every high phase and every low phase of `sclk` lasts exactly HALF_DIV system cycles. A frame has exactly 24 rising edges, and `sclk` is high only while `cs_n` is low. The default HALF_DIV of 11 at a 100 MHz clock gives about 4.55 MHz, below the 4.8 MHz limit.
- R4: The data line is sampled on each rising edge of `sclk`, and bit k of the frame is the k-th bit sampled.
- R5: `result[13]` through `result[0]` are sampled bits 9 through 22, in that order.
- R6: `status[1]` is sampled bit 23 and `status[0]` is sampled bit 24.
- R7: `done` is high for exactly one system cycle, right after the 24th high phase ends. In that same cycle `cs_n` is 1 and `sclk` is 0.
- R8: `frame_error` is 1 in the `done` cycle if any of sampled bits 1 through 8 is 1, and 0 otherwise. It is never 1 outside a `done` cycle.
- R9: A `start` that arrives while `busy` is 1 is ignored. This includes a `start` in the `done` cycle. It neither restarts nor adds a frame.
- R10: `result` and `status` hold their values after `done` until the next accepted `start`.
- R11: `busy` is 1 from the cycle after an accepted `start` through the `done` cycle, and 0 in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to read a frame |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low converter select |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame-complete strobe |
| frame_error | output | 1 | Leading byte was nonzero (valid with done) |
| result | output | 14 | Conversion result, MSB at bit 13 |
| status | output | 2 | Trailing status bits, first received at bit 1 |

## Verification
The bench targets several corner cases, and each catches a specific class of bug:
- All-ones, all-zeros and alternating result patterns expose a result window shifted by one bit, or a swapped status pair, as a scoreboard mismatch.
- Single ones at either end of the leading byte catch an error check that covers only part of that byte.
- Phase widths are measured from `cs_n` fall to the final clock fall, which catches an off-by-one in the divider or a missing setup phase.
- `start` pulses are sent in mid-frame and in the `done` cycle. A design that accepted them would restart, produce more or fewer than 24 edges, or emit an extra `done`.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_DONE
    } rd_state_t;

endpackage

// File: rtl/adc_rd_phase_timer.sv
module adc_rd_phase_timer #(
    parameter int HALF_DIV = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (HALF_DIV <= 1) begin : g_every_cycle
            assign tick = run;
        end else begin : g_counted
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!run || tick) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);

            // R3: the phase counter never runs past its last value
            a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
                cnt <= LAST);
        end
    endgenerate

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             din,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clear) begin
            q <= '0;
        end else if (shift) begin
            q <= {q[WIDTH-2:0], din};
        end
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV    = 11,
    parameter int LEAD_BITS   = 8,
    parameter int RESULT_BITS = 14,
    parameter int STATUS_BITS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   miso,
    output logic                   sclk,
    output logic                   cs_n,
    output logic                   busy,
    output logic                   done,
    output logic                   frame_error,
    output logic [RESULT_BITS-1:0] result,
    output logic [STATUS_BITS-1:0] status
);

    localparam int FRAME_BITS = LEAD_BITS + RESULT_BITS + STATUS_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS);

    rd_state_t              state, state_nx;
    logic [CNT_W-1:0]       bit_cnt;
    logic [FRAME_BITS-1:0]  frame;
    logic                   tick;
    logic                   timer_run;
    logic                   accept;
    logic                   sample;

    assign accept    = start && (state == ST_IDLE);
    assign timer_run = (state == ST_SETUP) || (state == ST_HIGH) || (state == ST_LOW);
    assign sample    = tick && ((state == ST_SETUP) || (state == ST_LOW));

    adc_rd_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (tick)
    );

    adc_rd_shifter #(.WIDTH(FRAME_BITS)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .shift (sample),
        .din   (miso),
        .q     (frame)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // sampled-bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (accept) begin
            bit_cnt <= '0;
        end else if (sample) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SETUP;
            ST_SETUP: if (tick)  state_nx = ST_HIGH;
            ST_HIGH:  if (tick)  state_nx = (bit_cnt == LAST_BIT) ? ST_DONE : ST_LOW;
            ST_LOW:   if (tick)  state_nx = ST_HIGH;
            ST_DONE:             state_nx = ST_IDLE;
            default:             state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sclk        = 1'b0;
        cs_n        = 1'b1;
        busy        = 1'b1;
        done        = 1'b0;
        frame_error = 1'b0;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_SETUP: cs_n = 1'b0;
            ST_HIGH:  begin cs_n = 1'b0; sclk = 1'b1; end
            ST_LOW:   cs_n = 1'b0;
            ST_DONE:  begin
                done        = 1'b1;
                frame_error = |frame[FRAME_BITS-1 -: LEAD_BITS];
            end
            default:  busy = 1'b0;
        endcase
    end

    assign result = frame[STATUS_BITS +: RESULT_BITS];
    assign status = frame[STATUS_BITS-1:0];

    // R7: the done strobe lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a frame completes only after all bits were sampled
    a_r7_all_bits: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bit_cnt == LAST_BIT));

    // R3: the serial clock toggles only while the converter is selected
    a_r3_sclk_selected: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R9: a frame in progress is never abandoned
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R8: the error flag appears only with done
    a_r8_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |-> done);

    // R10: outputs hold while idle
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(result) && $stable(status)));

    // R1: idle bus levels
    a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk));

endmodule

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;

    localparam int HALF = 11;

    typedef struct packed {
        logic [13:0] res;
        logic [1:0]  st;
        logic        err;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        miso;
    logic        sclk, cs_n, busy, done, frame_error;
    logic [13:0] result;
    logic [1:0]  status;

    int errors = 0;
    int checks = 0;

    exp_t        expq[$];
    logic [23:0] tx_frame = '0;
    int          idx = 0;

    // monitor state
    logic cs_prev = 1'b1;
    logic done_prev = 1'b0;
    logic lvl = 1'b0;
    int   len = 0;
    int   rises = 0;
    logic width_bad = 1'b0;

    always #5 clk = ~clk;

    adc_frame_reader #(.HALF_DIV(HALF)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .miso        (miso),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .busy        (busy),
        .done        (done),
        .frame_error (frame_error),
        .result      (result),
        .status      (status)
    );

    // converter model: first bit on select, next bit on each falling clock
    always @(negedge cs_n) idx = 0;
    always @(negedge sclk) if (!cs_n) idx = idx + 1;
    assign miso = (!cs_n && idx < 24) ? tx_frame[23 - idx] : 1'b0;

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: phase widths, edge count and scoreboard compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n) begin
                if (cs_prev) begin
                    lvl = 1'b0; len = 1; rises = 0;
                    width_bad = sclk;
                end else if (sclk == lvl) begin
                    len++;
                end else begin
                    if (len != HALF) width_bad = 1'b1;
                    if (sclk) rises++;
                    lvl = sclk;
                    len = 1;
                end
            end else if (!cs_prev) begin
                if (len != HALF || lvl != 1'b1) width_bad = 1'b1;
            end
            if (done) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(result == e.res, "R5 result", 32'(result), 32'(e.res));
                    check(status == e.st, "R6 status", 32'(status), 32'(e.st));
                    check(frame_error == e.err, "R8 frame_error",
                          32'(frame_error), 32'(e.err));
                    check(rises == 24, "R3 rising edge count", 32'(rises), 32'd24);
                    check(!width_bad, "R2/R3 phase widths", 32'(width_bad), 32'd0);
                    check(cs_n && !sclk && busy, "R7/R11 bus at done",
                          {29'd0, cs_n, sclk, busy}, 32'b101);
                end
            end
            if (done && done_prev) check(1'b0, "R7 done longer than one cycle", 32'd1, 32'd0);
            if (frame_error && !done) check(1'b0, "R8 error outside done", 32'd1, 32'd0);
            done_prev = done;
            cs_prev   = cs_n;
        end
    end

    task automatic run_frame(input logic [7:0] lead, input logic [13:0] res,
                             input logic [1:0] st, input logic mid_start,
                             input logic done_start);
        exp_t e;
        e.res = res; e.st = st; e.err = |lead;
        while (busy) @(negedge clk);
        tx_frame = {lead, res, st};
        expq.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !cs_n, "R2/R11 select and busy after start",
              {30'd0, busy, cs_n}, 32'b10);
        if (mid_start) begin
            repeat (100) @(negedge clk);
            start = 1'b1;                 // R9: ignored mid-frame
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        if (done_start) begin
            start = 1'b1;                 // R9: sampled in the done cycle
            @(negedge clk);
            start = 1'b0;
        end else begin
            @(negedge clk);
        end
        check(!busy, "R11 busy clears after done", 32'(busy), 32'd0);
        repeat (30) @(negedge clk);
        check(!busy && cs_n, "R9 no new frame", {30'd0, busy, cs_n}, 32'b01);
        check(result == res && status == st, "R10 outputs held",
              {16'd0, result, status}, {16'd0, res, st});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n && !sclk && !busy && !done && !frame_error, "R1 reset state",
              {27'd0, cs_n, sclk, busy, done, frame_error}, 32'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_frame(8'h00, 14'h3FFF, 2'b11, 1'b0, 1'b0);   // R4 R5 R6
        run_frame(8'h00, 14'h0000, 2'b00, 1'b0, 1'b0);
        run_frame(8'h00, 14'h2AAA, 2'b10, 1'b0, 1'b0);
        run_frame(8'h00, 14'h1555, 2'b01, 1'b1, 1'b0);   // R9 mid-frame
        run_frame(8'h80, 14'h2001, 2'b10, 1'b0, 1'b1);   // R8, R9 at done
        run_frame(8'h01, 14'h0F0F, 2'b01, 1'b0, 1'b0);   // R8
        run_frame(8'h00, 14'h2000, 2'b00, 1'b0, 1'b0);   // R4 MSB alone
        run_frame(8'hFF, 14'h0001, 2'b11, 1'b0, 1'b0);
        check(expq.size() == 0, "R9 all frames completed", 32'(expq.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule